// File: doc/BRIEF.md
# Latched 4-to-16 Line Decoder

This block turns a 4-bit address into a selection of one line out of sixteen. The address first passes through a hold stage. While the latch-enable input is high the stage is transparent and the outputs track the address in the same cycle. While latch-enable is low the stage keeps the address it had on the last clock edge at which latch-enable was high, and later address changes have no effect.

An active-low strobe acts directly on the output stage and is never stored. With the strobe high no line is selected. Because the strobe is not stored, it can carry a serial data bit that the held address steers to one of the sixteen lines, which makes the block a 1-to-16 demultiplexer. The strobe can also serve as a chip select when several decoders share one address bus.

A parameter selects the output polarity. In the true variant the chosen line is driven high and the others low. In the complement variant the chosen line is driven low and the others high. A synchronous reset clears the held address to zero.

Top module: `latched_decoder`

## Requirements
- R1: After a synchronous reset, with latch-enable low and strobe low, the block selects line 0, so the held address is 0.
- R2: While `le` is 1, the outputs reflect the current value of `a` combinationally, without waiting for a clock edge.
- R3: While `le` is 0, changes on `a` do not change `y`. The selection stays at the address sampled on the last rising clock edge at which `le` was 1.
- R4: Address value n (0 to 15, with `a[0]` as the least significant bit) selects output bit `y[n]`.
- R5: With `strobe_n` at 0, exactly one bit of `y` is at the active level.
- R6: With `strobe_n` at 1, every bit of `y` is at the inactive level, whatever the address. That is all zeros when `ACTIVE_HIGH`=1 and all ones when `ACTIVE_HIGH`=0.
- R7: With `ACTIVE_HIGH`=1 the selected bit is 1 and the rest are 0. With `ACTIVE_HIGH`=0 the output is the bitwise inverse of that pattern.
- R8: `strobe_n` takes effect immediately even while `le` is 0. Toggling it switches the held line between active and inactive without disturbing the held address.
- R9: When `le` returns to 1, the outputs again follow the present value of `a`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock that samples the address into the hold register |
| rst | input | 1 | Synchronous reset, active high, clears the held address |
| le | input | 1 | Latch enable: 1 = transparent, 0 = hold |
| strobe_n | input | 1 | Active-low output strobe / demultiplexer data |
| a | input | 4 | Select address, bit 0 least significant |
| y | output | 16 | Decoded lines, polarity set by `ACTIVE_HIGH` |

## Verification
The assertions assume that the address is a legal setup-and-hold input. On the clock edge where latch-enable is first seen low, `a` must equal its value on the previous edge, so the captured value is unambiguous. The stimulus changes `le`, `strobe_n` and `a` only at falling clock edges. It always drops `le` while repeating the address it presented during the transparent cycle, and only then moves the address to new values. The strobe is free to change in any cycle, because nothing in the block stores it.

// File: rtl/ldec_pkg.sv
package ldec_pkg;

  typedef enum logic {
    POL_COMPLEMENT = 1'b0,
    POL_TRUE       = 1'b1
  } ldec_pol_e;

  function automatic ldec_pol_e pol_of(int active_high);
    return (active_high != 0) ? POL_TRUE : POL_COMPLEMENT;
  endfunction

  // level an unselected line rests at
  function automatic logic idle_level(ldec_pol_e pol);
    return (pol == POL_TRUE) ? 1'b0 : 1'b1;
  endfunction

endpackage

// File: rtl/ldec_addr_hold.sv
module ldec_addr_hold #(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              le,
  input  logic [ADDR_W-1:0] a_in,
  output logic [ADDR_W-1:0] addr_eff
);

  logic [ADDR_W-1:0] held_q;

  always_ff @(posedge clk) begin
    if (rst)
      held_q <= '0;
    else if (le)
      held_q <= a_in;
  end

  // transparent path while enabled, frozen value otherwise
  assign addr_eff = le ? a_in : held_q;

endmodule

// File: rtl/ldec_onehot.sv
module ldec_onehot #(
  parameter int ADDR_W = 4,
  parameter int OUT_N  = 1 << ADDR_W
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [OUT_N-1:0]  sel
);

  for (genvar i = 0; i < OUT_N; i++) begin : g_line
    assign sel[i] = (addr == ADDR_W'(i));
  end

endmodule

// File: rtl/ldec_polarity.sv
module ldec_polarity #(
  parameter int OUT_N       = 16,
  parameter int ACTIVE_HIGH = 1
) (
  input  logic [OUT_N-1:0] sel,
  input  logic             strobe_n,
  output logic [OUT_N-1:0] y
);
  import ldec_pkg::*;

  localparam ldec_pol_e POL = pol_of(ACTIVE_HIGH);

  logic [OUT_N-1:0] gated;
  assign gated = strobe_n ? '0 : sel;

  if (POL == POL_TRUE) begin : g_true
    assign y = gated;
  end else begin : g_comp
    assign y = ~gated;
  end

endmodule

// File: rtl/latched_decoder.sv
module latched_decoder #(
  parameter int ADDR_W      = 4,
  parameter int ACTIVE_HIGH = 1,
  localparam int OUT_N      = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              le,
  input  logic              strobe_n,
  input  logic [ADDR_W-1:0] a,
  output logic [OUT_N-1:0]  y
);

  logic [ADDR_W-1:0] addr_eff;
  logic [OUT_N-1:0]  sel_onehot;

  ldec_addr_hold #(.ADDR_W(ADDR_W)) u_hold (
    .clk      (clk),
    .rst      (rst),
    .le       (le),
    .a_in     (a),
    .addr_eff (addr_eff)
  );

  ldec_onehot #(.ADDR_W(ADDR_W), .OUT_N(OUT_N)) u_dec (
    .addr (addr_eff),
    .sel  (sel_onehot)
  );

  ldec_polarity #(.OUT_N(OUT_N), .ACTIVE_HIGH(ACTIVE_HIGH)) u_pol (
    .sel      (sel_onehot),
    .strobe_n (strobe_n),
    .y        (y)
  );

endmodule

// File: rtl/ldec_checker.sv
module ldec_checker #(
  parameter int ADDR_W      = 4,
  parameter int ACTIVE_HIGH = 1,
  localparam int OUT_N      = 1 << ADDR_W
) (
  input logic              clk,
  input logic              rst,
  input logic              le,
  input logic              strobe_n,
  input logic [ADDR_W-1:0] a,
  input logic [ADDR_W-1:0] addr_eff,
  input logic [OUT_N-1:0]  y
);

  localparam logic ACT = (ACTIVE_HIGH != 0);

  logic [OUT_N-1:0] y_true;
  assign y_true = ACT ? y : ~y;

  // input discipline: address steady across the edge where le is first low
  addr_setup_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(le) |-> $stable(a));

  // R2
  transparent_chk: assert property (@(posedge clk) disable iff (rst)
    le |-> (addr_eff == a));

  // R3
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!le && !$past(le) && !$past(rst)) |-> $stable(addr_eff));

  // R4
  line_map_chk: assert property (@(posedge clk) disable iff (rst)
    !strobe_n |-> (y[addr_eff] == ACT));

  // R5
  one_active_chk: assert property (@(posedge clk) disable iff (rst)
    !strobe_n |-> ($countones(y_true) == 1));

  // R6
  all_idle_chk: assert property (@(posedge clk) disable iff (rst)
    strobe_n |-> (y == {OUT_N{~ACT}}));

endmodule

bind latched_decoder ldec_checker #(
  .ADDR_W(ADDR_W), .ACTIVE_HIGH(ACTIVE_HIGH)
) u_ldec_checker (
  .clk(clk), .rst(rst), .le(le), .strobe_n(strobe_n),
  .a(a), .addr_eff(addr_eff), .y(y)
);

// File: tb/test_latched_decoder.sv
module test_latched_decoder;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        le = 1'b0;
  logic        sn = 1'b0;
  logic [3:0]  a = 4'd9;
  logic [15:0] y_t, y_c;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  latched_decoder #(.ADDR_W(4), .ACTIVE_HIGH(1)) i_latched_decoder (
    .clk(clk), .rst(rst), .le(le), .strobe_n(sn), .a(a), .y(y_t));

  latched_decoder #(.ADDR_W(4), .ACTIVE_HIGH(0)) i_latched_decoder_cmp (
    .clk(clk), .rst(rst), .le(le), .strobe_n(sn), .a(a), .y(y_c));

  function automatic logic [15:0] expect_y(bit act_hi, bit s_n, int idx);
    logic [15:0] v;
    v = 16'(1) << idx;
    if (s_n) v = '0;
    return act_hi ? v : ~v;
  endfunction

  task automatic check(string tag, int idx);
    logic [15:0] et, ec;
    et = expect_y(1'b1, sn, idx);
    ec = expect_y(1'b0, sn, idx);
    checks += 2;
    if (y_t !== et) begin
      errors++;
      $display("FAIL %s true: y=%h expected %h", tag, y_t, et);
    end
    if (y_c !== ec) begin
      errors++;
      $display("FAIL %s complement: y=%h expected %h", tag, y_c, ec);
    end
  endtask

  task automatic step(bit l, bit s, logic [3:0] av);
    @(negedge clk);
    le = l; sn = s; a = av;
    #5;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #5;
    check("R1", 0);

    // transparent sweep, both strobe levels
    for (int s = 0; s < 2; s++) begin
      for (int v = 0; v < 16; v++) begin
        step(1'b1, s[0], v[3:0]);
        check(s == 0 ? "R2 R4 R5 R7" : "R6 R7", v);
      end
    end

    // hold, strobe passthrough, reopen
    for (int v = 0; v < 16; v++) begin
      step(1'b1, 1'b0, v[3:0]);
      step(1'b0, 1'b0, v[3:0]);
      check("R3", v);
      for (int d = 1; d < 16; d++) begin
        step(1'b0, 1'b0, 4'((v + d) % 16));
        check("R3", v);
      end
      step(1'b0, 1'b1, 4'((v + 7) % 16));
      check("R8", v);
      step(1'b0, 1'b0, 4'((v + 7) % 16));
      check("R8", v);
      step(1'b1, 1'b0, 4'((v + 7) % 16));
      check("R9", (v + 7) % 16);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule